// File: doc/BRIEF.md
# Comparator-Driven Digital Potentiometer Controller

This block steers the wiper of a 256-position digital potentiometer. The potentiometer sets the gate bias of a power amplifier. An external comparator reports whether the sensed quiescent current is above or below its target. While chip-select is high, every rising edge of a slow serial clock moves the wiper one tap in the direction the comparator asks for. Repeated steps drive the bias towards the target point. The wiper stops at either end of its range and does not wrap.

The wiper position can be committed to a modelled non-volatile register. A volatile write-enable latch must first be set through a simple register write. Next, an address-only bus write arms the store while chip-select is high. The store is then launched when chip-select falls while the serial clock is low. For a fixed number of cycles afterwards the block reports busy, and it accepts no steps and no further stores. At power-on reset the wiper is reloaded from the non-volatile register. A shutdown input turns the output enable off but leaves the wiper untouched. The comparator bit is passed out again as a status bit, so that a bias stuck on the high side can be spotted after calibration.

Top module: `biaspot_ctrl`

## Requirements
- R1: The serial clock and chip-select each pass through a two-flop synchronizer before edge detection. A serial clock rise that is sampled high at clock edge k changes the wiper at edge k+2.
- R2: A step happens only while the synchronized chip-select is high. The step moves the wiper up by one when cmp_bit is 1 and down by one when cmp_bit is 0. Serial clock rises while chip-select is low leave the wiper unchanged.
- R3: The wiper saturates: an up step at 255 keeps 255, a down step at 0 keeps 0, and the wiper never wraps.
- R4: Reset loads the wiper from the non-volatile register. That register holds NV_INIT (default 0x80) until the first store, and reset does not change it.
- R5: Two register writes control the write-enable latch, both at address 0x0F: data 0x02 sets it and data 0x00 clears it. Any other data, or any other address, leaves it unchanged. Reset clears it. While it is clear, no store changes nv_value.
- R6: A bus_addr_only pulse seen while the synchronized chip-select is high arms a store. The next synchronized chip-select fall launches the store if four conditions hold: the store is armed, the latch is set, the synchronized serial clock is low, and the block is not busy. The launch copies the current wiper into nv_value. A fall with the serial clock high stores nothing.
- R7: The armed flag is cleared by a bus_start pulse and by every synchronized chip-select fall, whether or not a store is launched. A later fall without a new arm stores nothing.
- R8: From the launch edge, busy stays high for WRITE_CYCLES cycles (default 16). While busy is high, wiper steps and further stores are blocked.
- R9: out_en is the inverse of shdn, registered one cycle, and is 0 during reset. Shutdown never changes the wiper.
- R10: cmp_status is cmp_bit, registered one cycle, and is 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset; acts as the power-on recall event |
| sclk_in | input | 1 | Asynchronous serial clock; its rises step the wiper |
| csel_in | input | 1 | Asynchronous chip-select; gates stepping; its fall launches a store |
| cmp_bit | input | 1 | Comparator result: 1 = current below target (step up), 0 = above (step down) |
| shdn | input | 1 | Shutdown request; forces out_en low |
| bus_start | input | 1 | One-cycle pulse: bus start condition seen (disarms the store) |
| bus_addr_only | input | 1 | One-cycle pulse: address-only write ended by a stop (arms the store) |
| reg_wr | input | 1 | One-cycle register write strobe |
| reg_addr | input | 8 | Register write address |
| reg_data | input | 8 | Register write data |
| wiper | output | 8 | Current wiper position |
| nv_value | output | 8 | Contents of the modelled non-volatile register |
| busy | output | 1 | Non-volatile write in progress |
| out_en | output | 1 | Bias output buffer enable |
| cmp_status | output | 1 | Registered copy of cmp_bit |

## Verification
A serial clock rise driven before edge k shows on the wiper after edge k+2. A chip-select fall driven before edge k launches a store whose nv_value and busy appear after edge k+2, and busy then stays high for WRITE_CYCLES cycles. out_en and cmp_status follow their inputs after a single edge. A behavioural model in the bench tracks these delays as short histories of the sampled inputs and compares every output one time unit after each rising edge. Inputs are driven on falling edges. The directed checks with fixed expected values are made only after windows longer than the longest of these latencies.

// File: rtl/biaspot_pkg.sv
package biaspot_pkg;

    localparam int TAP_W  = 8;
    localparam int REG_AW = 8;
    localparam int REG_DW = 8;

    typedef logic [TAP_W-1:0] tap_t;

    localparam tap_t TAP_TOP    = '1;
    localparam tap_t TAP_BOTTOM = '0;

    localparam logic [REG_AW-1:0] LATCH_ADDR = 8'h0F;
    localparam logic [REG_DW-1:0] LATCH_ON   = 8'h02;
    localparam logic [REG_DW-1:0] LATCH_OFF  = 8'h00;

    typedef enum logic [1:0] {
        LATCH_HOLD,
        LATCH_SET,
        LATCH_CLEAR
    } latch_op_e;

    // synchronized level plus the level one cycle earlier
    typedef struct packed {
        logic now;
        logic was;
    } sync_pair_t;

    function automatic logic pair_rise(sync_pair_t p);
        return p.now & ~p.was;
    endfunction

    function automatic logic pair_fall(sync_pair_t p);
        return ~p.now & p.was;
    endfunction

    function automatic tap_t tap_move(tap_t cur, logic up);
        if (up)
            return (cur == TAP_TOP) ? cur : cur + 1'b1;
        else
            return (cur == TAP_BOTTOM) ? cur : cur - 1'b1;
    endfunction

    function automatic latch_op_e latch_decode(logic wr,
                                               logic [REG_AW-1:0] addr,
                                               logic [REG_DW-1:0] data);
        if (!wr || addr != LATCH_ADDR)
            return LATCH_HOLD;
        if (data == LATCH_ON)
            return LATCH_SET;
        if (data == LATCH_OFF)
            return LATCH_CLEAR;
        return LATCH_HOLD;
    endfunction

endpackage

// File: rtl/biaspot_sync.sv
module biaspot_sync
    import biaspot_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       din,
    output sync_pair_t pair
);

    logic [STAGES-1:0] chain;
    logic              last;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b0;
                else     chain[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b0;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last <= 1'b0;
        else     last <= chain[STAGES-1];
    end

    assign pair.now = chain[STAGES-1];
    assign pair.was = last;

endmodule

// File: rtl/biaspot_wiper.sv
module biaspot_wiper
    import biaspot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  tap_t       recall,
    input  sync_pair_t sclk_s,
    input  sync_pair_t cs_s,
    input  logic       cmp_bit,
    input  logic       busy,
    output tap_t       wiper
);

    logic step_en;
    assign step_en = pair_rise(sclk_s) & cs_s.now & ~busy;

    always_ff @(posedge clk) begin
        if (rst)
            wiper <= recall;
        else if (step_en)
            wiper <= tap_move(wiper, cmp_bit);
    end

    AST_SINGLE_TAP: assert property (@(posedge clk) disable iff (rst)
        (wiper != $past(wiper)) |->
            ((tap_t'(wiper - $past(wiper)) == tap_t'(1)) ||
             (tap_t'($past(wiper) - wiper) == tap_t'(1)))); // R2

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        !((wiper == TAP_BOTTOM && $past(wiper) == TAP_TOP) ||
          (wiper == TAP_TOP && $past(wiper) == TAP_BOTTOM))); // R3

    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(wiper)); // R8

endmodule

// File: rtl/biaspot_store.sv
module biaspot_store
    import biaspot_pkg::*;
#(
    parameter int   WRITE_CYCLES = 16,
    parameter tap_t NV_INIT      = 8'h80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_level,
    input  sync_pair_t        cs_s,
    input  logic              bus_start,
    input  logic              bus_addr_only,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_data,
    input  tap_t              wiper,
    output tap_t              nv_value,
    output logic              busy
);

    localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WRITE_CYCLES);

    logic             latch_q;
    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;
    tap_t             nv_q = NV_INIT;   // non-volatile: untouched by reset
    latch_op_e        op;
    logic             cs_fall;
    logic             launch;

    assign op      = latch_decode(reg_wr, reg_addr, reg_data);
    assign cs_fall = pair_fall(cs_s);
    assign busy    = (cnt_q != '0);
    assign launch  = cs_fall & armed_q & latch_q & ~busy & ~sclk_level;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= 1'b0;
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            unique case (op)
                LATCH_SET:   latch_q <= 1'b1;
                LATCH_CLEAR: latch_q <= 1'b0;
                default:     latch_q <= latch_q;
            endcase
            if (bus_start || cs_fall)
                armed_q <= 1'b0;
            else if (bus_addr_only && cs_s.now)
                armed_q <= 1'b1;
            if (launch)
                cnt_q <= CNT_LOAD;
            else if (busy)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && launch)
            nv_q <= wiper;
    end

    assign nv_value = nv_q;

    AST_NV_NEEDS_LATCH: assert property (@(posedge clk) disable iff (rst)
        (nv_q != $past(nv_q)) |-> $past(latch_q)); // R5

    AST_NV_WRITE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (nv_q != $past(nv_q)) |-> busy); // R8

    AST_BUSY_NO_STORE: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(nv_q)); // R8

    AST_START_DISARMS: assert property (@(posedge clk) disable iff (rst)
        bus_start |=> !armed_q); // R7

endmodule

// File: rtl/biaspot_ctrl.sv
module biaspot_ctrl
    import biaspot_pkg::*;
#(
    parameter int   WRITE_CYCLES = 16,
    parameter int   SYNC_STAGES  = 2,
    parameter tap_t NV_INIT      = 8'h80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_in,
    input  logic              csel_in,
    input  logic              cmp_bit,
    input  logic              shdn,
    input  logic              bus_start,
    input  logic              bus_addr_only,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_data,
    output logic [TAP_W-1:0]  wiper,
    output logic [TAP_W-1:0]  nv_value,
    output logic              busy,
    output logic              out_en,
    output logic              cmp_status
);

    sync_pair_t sclk_s;
    sync_pair_t cs_s;
    tap_t       wiper_w;
    tap_t       nv_w;
    logic       busy_w;

    biaspot_sync #(.STAGES(SYNC_STAGES)) u_sclk_sync (
        .clk (clk), .rst (rst), .din (sclk_in), .pair (sclk_s)
    );

    biaspot_sync #(.STAGES(SYNC_STAGES)) u_cs_sync (
        .clk (clk), .rst (rst), .din (csel_in), .pair (cs_s)
    );

    biaspot_wiper u_wiper (
        .clk     (clk),
        .rst     (rst),
        .recall  (nv_w),
        .sclk_s  (sclk_s),
        .cs_s    (cs_s),
        .cmp_bit (cmp_bit),
        .busy    (busy_w),
        .wiper   (wiper_w)
    );

    biaspot_store #(
        .WRITE_CYCLES (WRITE_CYCLES),
        .NV_INIT      (NV_INIT)
    ) u_store (
        .clk           (clk),
        .rst           (rst),
        .sclk_level    (sclk_s.now),
        .cs_s          (cs_s),
        .bus_start     (bus_start),
        .bus_addr_only (bus_addr_only),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_data      (reg_data),
        .wiper         (wiper_w),
        .nv_value      (nv_w),
        .busy          (busy_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_en     <= 1'b0;
            cmp_status <= 1'b0;
        end else begin
            out_en     <= ~shdn;
            cmp_status <= cmp_bit;
        end
    end

    assign wiper    = wiper_w;
    assign nv_value = nv_w;
    assign busy     = busy_w;

    AST_SHDN_OFF: assert property (@(posedge clk) disable iff (rst)
        shdn |=> !out_en); // R9

endmodule

// File: tb/biaspot_ctrl_test.sv
module biaspot_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int WR_CYC     = 16;
    localparam int NV_START   = 8'h80;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk_in = 1'b0;
    logic       csel_in = 1'b0;
    logic       cmp_bit = 1'b0;
    logic       shdn = 1'b0;
    logic       bus_start = 1'b0;
    logic       bus_addr_only = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_data = 8'h00;
    logic [7:0] wiper;
    logic [7:0] nv_value;
    logic       busy;
    logic       out_en;
    logic       cmp_status;

    int checks = 0;
    int errors = 0;

    biaspot_ctrl #(
        .WRITE_CYCLES (WR_CYC),
        .SYNC_STAGES  (2),
        .NV_INIT      (8'h80)
    ) uut (
        .clk (clk), .rst (rst), .sclk_in (sclk_in), .csel_in (csel_in),
        .cmp_bit (cmp_bit), .shdn (shdn), .bus_start (bus_start),
        .bus_addr_only (bus_addr_only), .reg_wr (reg_wr),
        .reg_addr (reg_addr), .reg_data (reg_data), .wiper (wiper),
        .nv_value (nv_value), .busy (busy), .out_en (out_en),
        .cmp_status (cmp_status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    // behavioural reference: input histories and integer state
    int  m_w, m_nv = NV_START, m_cnt, m_arm, m_latch, m_oe, m_cst;
    int  sh[3];
    int  ch[3];
    bit  started = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_w = m_nv; m_cnt = 0; m_arm = 0; m_latch = 0; m_oe = 0; m_cst = 0;
            for (int i = 0; i < 3; i++) begin sh[i] = 0; ch[i] = 0; end
            started = 1;
        end else begin
            int nw;
            bit rise_ev, fall_ev, bsy;
            rise_ev = (sh[1] == 1) && (sh[2] == 0);
            fall_ev = (ch[1] == 0) && (ch[2] == 1);
            bsy = (m_cnt != 0);
            nw = m_w;
            if (rise_ev && ch[1] == 1 && !bsy)
                nw = cmp_bit ? ((m_w < 255) ? m_w + 1 : 255) : ((m_w > 0) ? m_w - 1 : 0);
            if (fall_ev && m_arm == 1 && m_latch == 1 && !bsy && sh[1] == 0) begin
                m_nv = m_w; m_cnt = WR_CYC;
            end else if (m_cnt > 0) begin
                m_cnt--;
            end
            m_w = nw;
            if (bus_start || fall_ev) m_arm = 0;
            else if (bus_addr_only && ch[1] == 1) m_arm = 1;
            if (reg_wr && reg_addr == 8'h0F) begin
                if (reg_data == 8'h02) m_latch = 1;
                else if (reg_data == 8'h00) m_latch = 0;
            end
            m_oe = shdn ? 0 : 1;
            m_cst = cmp_bit ? 1 : 0;
            sh[2] = sh[1]; sh[1] = sh[0]; sh[0] = sclk_in ? 1 : 0;
            ch[2] = ch[1]; ch[1] = ch[0]; ch[0] = csel_in ? 1 : 0;
        end
        #1;
        if (started) begin
            check("R2 R3", "model wiper", wiper, m_w);
            check("R6", "model nv_value", nv_value, m_nv);
            check("R8", "model busy", busy, (m_cnt != 0));
            check("R9", "model out_en", out_en, m_oe);
            check("R10", "model cmp_status", cmp_status, m_cst);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            sclk_in = 1'b1; idle(3);
            sclk_in = 1'b0; idle(3);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_data = d;
        idle(1);
        reg_wr = 1'b0;
    endtask

    task automatic arm_pulse();
        bus_addr_only = 1'b1; idle(1); bus_addr_only = 1'b0;
    endtask

    task automatic store_seq();
        csel_in = 1'b1; idle(4);
        arm_pulse(); idle(2);
        csel_in = 1'b0; idle(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(2);
        check("R4", "wiper after reset", wiper, 8'h80);
        check("R4", "nv after reset", nv_value, 8'h80);
        check("R8", "busy after reset", busy, 0);
        check("R9", "out_en released", out_en, 1);

        // R1 latency of a single step
        csel_in = 1'b1; cmp_bit = 1'b1; idle(4);
        sclk_in = 1'b1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        check("R1", "wiper one edge after sample", wiper, 8'h80);
        @(posedge clk); #1;
        check("R1", "wiper two edges after sample", wiper, 8'h81);
        @(negedge clk);
        sclk_in = 1'b0; idle(3);

        pulses(4);
        check("R2", "up steps", wiper, 8'h85);
        csel_in = 1'b0; idle(4);
        pulses(3);
        check("R2", "steps without chip-select", wiper, 8'h85);

        csel_in = 1'b1; idle(4);
        cmp_bit = 1'b0;
        pulses(200);
        check("R3", "bottom saturation", wiper, 8'h00);
        cmp_bit = 1'b1;
        pulses(300);
        check("R3", "top saturation", wiper, 8'hFF);
        cmp_bit = 1'b0;
        pulses(60);
        check("R2", "down steps", wiper, 8'hC3);

        store_seq();
        check("R5", "store refused with latch clear", nv_value, 8'h80);
        reg_write(8'h0E, 8'h02);
        reg_write(8'h0F, 8'h05);
        store_seq();
        check("R5", "store refused after unrelated writes", nv_value, 8'h80);
        check("R5", "no busy when refused", busy, 0);

        reg_write(8'h0F, 8'h02);
        store_seq();
        check("R6", "store copies wiper", nv_value, 8'hC3);
        check("R8", "busy during write", busy, 1);
        csel_in = 1'b1; idle(2);
        pulses(1);
        check("R8", "step blocked while busy", wiper, 8'hC3);
        idle(20);
        check("R8", "busy released", busy, 0);

        cmp_bit = 1'b1;
        pulses(2);
        check("R2", "steps after busy", wiper, 8'hC5);
        arm_pulse(); idle(1);
        bus_start = 1'b1; idle(1); bus_start = 1'b0; idle(2);
        csel_in = 1'b0; idle(4);
        check("R7", "start disarms store", nv_value, 8'hC3);

        csel_in = 1'b1; idle(4);
        arm_pulse(); idle(2);
        sclk_in = 1'b1; idle(4);
        csel_in = 1'b0; idle(4);
        sclk_in = 1'b0; idle(3);
        check("R6", "no store with serial clock high", nv_value, 8'hC3);
        check("R2", "step before that fall", wiper, 8'hC6);
        csel_in = 1'b1; idle(4);
        csel_in = 1'b0; idle(4);
        check("R7", "fall without new arm", nv_value, 8'hC3);

        reg_write(8'h0F, 8'h00);
        store_seq();
        check("R5", "store refused after latch cleared", nv_value, 8'hC3);

        shdn = 1'b1; idle(2);
        check("R9", "out_en in shutdown", out_en, 0);
        shdn = 1'b0; idle(2);
        check("R9", "out_en resumed", out_en, 1);
        check("R9", "wiper kept through shutdown", wiper, 8'hC6);

        cmp_bit = 1'b0; idle(2);
        check("R10", "status low", cmp_status, 0);
        cmp_bit = 1'b1; idle(2);
        check("R10", "status high", cmp_status, 1);

        rst = 1'b1; idle(3);
        rst = 1'b0; idle(2);
        check("R4", "recall after reset", wiper, 8'hC3);
        check("R4", "nv kept through reset", nv_value, 8'hC3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule